// File: doc/BRIEF.md
# Focus Search and Close Controller

This controller runs focus acquisition for an optical pickup. A start command launches a search: the block produces a signed triangular drive value that moves the lens up and down between programmable limits. At the same time it watches a stream of signed focus-error samples, one per clock, and an RF-present flag. When the lens is travelling toward the disc, RF is present and the focus error changes sign, it hands the lens over to the closed focus loop and freezes the search drive.

After closing, the controller waits a programmable number of millisecond ticks. It then samples a low-pass-filtered RF-present flag. If the flag is high, lock is confirmed and the loop stays closed. If it is low, the loop is opened, the drive returns to zero and a failure flag is raised; the block then idles until the next start. For a programmable number of millisecond ticks at the start of each search, focus-error sign changes are ignored, so that settling transients cannot close the loop.

Ramp amplitude, ramp step, blind length and check delay are configuration inputs. They must be held steady while a search or check is in progress.

Top module: `focus_acq_ctrl`

## Requirements
- R1: After reset the controller is idle: search_drv is 0 and search_busy, loop_closed, lock_pass and lock_fail are all low.
- R2: A start pulse, in any state, begins a new search on the next clock. search_busy goes high, search_drv is 0, the ramp direction is upward (toward the disc), the millisecond count is 0, and lock_pass and lock_fail are cleared.
- R3: While searching, each clock moves search_drv by cfg_step. Going up, if the new value would reach or pass +cfg_amp, search_drv becomes +cfg_amp and the direction turns downward. Going down, if the new value would reach or pass -cfg_amp, search_drv becomes -cfg_amp and the direction turns upward.
- R4: The loop closes only in a clock where three conditions hold together: the ramp direction is upward (positive drive is toward the disc), rf_present is 1, and a focus-error zero crossing is seen.
- R5: A zero crossing means that the sign bit (MSB) of fe_smp differs from the sign bit of the previous clock's sample. A value of zero counts as non-negative. The first sample after start has no predecessor and is never a crossing.
- R6: Crossings are ignored while fewer than cfg_blind_ms millisecond ticks have been counted since start. A value of 0 means there is no blind period.
- R7: When the loop closes, search_busy falls and loop_closed rises on the same clock edge, and search_drv holds the value it had at that moment.
- R8: After closing, the check happens on the first ms_tick that brings the count of ticks since closing to at least cfg_chk_ms. A value of 0 means the first tick. If rf_present_lpf is 1 at that tick, lock_pass rises and the loop stays closed until the next start.
- R9: If rf_present_lpf is 0 at the check, lock_fail rises, loop_closed falls and search_drv returns to 0. The block then stays idle, and ignores focus error and RF, until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search (one-clock pulse) |
| cfg_amp | input | DW-1 | Ramp peak magnitude |
| cfg_step | input | DW-1 | Ramp increment per clock |
| cfg_blind_ms | input | TW | Blind period in ms ticks |
| cfg_chk_ms | input | TW | Delay from close to lock check in ms ticks |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| fe_smp | input | EW | Signed focus-error sample, one per clock |
| rf_present | input | 1 | RF-present flag |
| rf_present_lpf | input | 1 | Low-pass-filtered RF-present flag |
| search_drv | output | DW | Signed search drive value |
| search_busy | output | 1 | High while searching |
| loop_closed | output | 1 | Selects the closed focus loop |
| lock_pass | output | 1 | Lock confirmed at the check |
| lock_fail | output | 1 | Lock lost at the check |

## Verification
The embedded assertions check, on every clock, the properties that involve only a few cycles: the drive stays within the programmed amplitude while searching, a close coincides with an upward ramp, RF present and a sign change, the handover freezes the drive, a failure opens the loop and zeroes the drive, and a start clears the result flags. Other behaviour spans many ticks or depends on the configuration, and only the bench scenarios can show it: the exact ramp trajectory with its turns at the limits, whether a crossing inside the blind period is ignored, which millisecond tick triggers the lock check, and the idle state after a failure. The bench therefore runs a cycle model beside the design and adds directed runs in which crossings occur only on the downward sweep, only without RF, or not at all.

// File: rtl/focus_acq_ctrl.sv
module focus_acq_ctrl #(
  parameter int DW = 12,
  parameter int EW = 12,
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DW-2:0]        cfg_amp,
  input  logic [DW-2:0]        cfg_step,
  input  logic [TW-1:0]        cfg_blind_ms,
  input  logic [TW-1:0]        cfg_chk_ms,
  input  logic                 ms_tick,
  input  logic signed [EW-1:0] fe_smp,
  input  logic                 rf_present,
  input  logic                 rf_present_lpf,
  output logic signed [DW-1:0] search_drv,
  output logic                 search_busy,
  output logic                 loop_closed,
  output logic                 lock_pass,
  output logic                 lock_fail
);

  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_VERIFY, ST_LOCKED} st_t;

  st_t              st;
  logic             dir_up;
  logic [TW-1:0]    ms_cnt;
  logic             fe_prev_neg;
  logic             prev_ok;

  logic signed [DW:0] drv_x, amp_x, step_x, up_val, dn_val;
  logic               xing, blind, close_now, chk_due;
  logic [TW:0]        cnt_inc;

  assign drv_x   = {search_drv[DW-1], search_drv};
  assign amp_x   = $signed({2'b00, cfg_amp});
  assign step_x  = $signed({2'b00, cfg_step});
  assign up_val  = drv_x + step_x;
  assign dn_val  = drv_x - step_x;
  assign xing    = prev_ok && (fe_prev_neg != fe_smp[EW-1]);
  assign blind   = ms_cnt < cfg_blind_ms;
  assign close_now = dir_up && rf_present && xing && !blind;
  assign cnt_inc = {1'b0, ms_cnt} + 1'b1;
  assign chk_due = cnt_inc >= {1'b0, cfg_chk_ms};

  assign search_busy = (st == ST_SEARCH);
  assign loop_closed = (st == ST_VERIFY) || (st == ST_LOCKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      search_drv  <= '0;
      dir_up      <= 1'b1;
      ms_cnt      <= '0;
      fe_prev_neg <= 1'b0;
      prev_ok     <= 1'b0;
      lock_pass   <= 1'b0;
      lock_fail   <= 1'b0;
    end else if (start) begin
      st          <= ST_SEARCH;
      search_drv  <= '0;
      dir_up      <= 1'b1;
      ms_cnt      <= '0;
      prev_ok     <= 1'b0;
      lock_pass   <= 1'b0;
      lock_fail   <= 1'b0;
    end else begin
      case (st)
        ST_SEARCH: begin
          fe_prev_neg <= fe_smp[EW-1];
          prev_ok     <= 1'b1;
          if (close_now) begin
            st     <= ST_VERIFY;
            ms_cnt <= '0;
          end else begin
            if (ms_tick && ms_cnt != '1) ms_cnt <= ms_cnt + 1'b1;
            if (dir_up) begin
              if (up_val >= amp_x) begin
                search_drv <= amp_x[DW-1:0];
                dir_up     <= 1'b0;
              end else begin
                search_drv <= up_val[DW-1:0];
              end
            end else begin
              if (dn_val <= -amp_x) begin
                search_drv <= -amp_x[DW-1:0];
                dir_up     <= 1'b1;
              end else begin
                search_drv <= dn_val[DW-1:0];
              end
            end
          end
        end
        ST_VERIFY: begin
          if (ms_tick) begin
            if (chk_due) begin
              if (rf_present_lpf) begin
                st        <= ST_LOCKED;
                lock_pass <= 1'b1;
              end else begin
                st         <= ST_IDLE;
                lock_fail  <= 1'b1;
                search_drv <= '0;
              end
            end else begin
              ms_cnt <= ms_cnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R3
  drive_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    search_busy |-> ($signed({search_drv[DW-1], search_drv}) <= amp_x &&
                     $signed({search_drv[DW-1], search_drv}) >= -amp_x));

  // R4
  close_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_closed) |-> ($past(dir_up) && $past(rf_present) &&
                            ($past(fe_smp[EW-1]) != $past(fe_prev_neg))));

  // R7
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(search_busy) |-> (loop_closed && $stable(search_drv)));

  // R9
  fail_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_fail) |-> (!loop_closed && !search_busy && search_drv == '0));

  // R8
  pass_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pass |-> (loop_closed && !lock_fail));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (search_busy && !lock_pass && !lock_fail && search_drv == '0));

endmodule

// File: tb/focus_acq_ctrl_test.sv
module focus_acq_ctrl_test;
  localparam int DW = 12, EW = 12, TW = 8;

  logic clk = 0, rst_n = 0, start = 0, ms_tick = 0, rf = 0, lpf = 0;
  logic [DW-2:0] amp = 0, stp = 0;
  logic [TW-1:0] blind = 0, chk = 0;
  logic signed [EW-1:0] fe = 0;
  logic signed [DW-1:0] drv;
  logic busy, closed, pass, fail;

  int checks = 0, errs = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  focus_acq_ctrl #(.DW(DW), .EW(EW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_amp(amp), .cfg_step(stp),
    .cfg_blind_ms(blind), .cfg_chk_ms(chk), .ms_tick(ms_tick), .fe_smp(fe),
    .rf_present(rf), .rf_present_lpf(lpf), .search_drv(drv), .search_busy(busy),
    .loop_closed(closed), .lock_pass(pass), .lock_fail(fail));

  // expected-state model (0 idle, 1 search, 2 verify, 3 locked)
  int m_st = 0, m_drv = 0, m_cnt = 0, m_prev = 0;
  bit m_up = 1, m_pv = 0, m_pass = 0, m_fail = 0;

  function automatic int ramp_val(int d, bit up, int a, int s);
    if (up) return (d + s >= a) ? a : d + s;
    return (d - s <= -a) ? -a : d - s;
  endfunction

  function automatic bit ramp_dir(int d, bit up, int a, int s);
    if (up) return (d + s >= a) ? 1'b0 : 1'b1;
    return (d - s <= -a) ? 1'b1 : 1'b0;
  endfunction

  function automatic bit sign_flip(int p, int c);
    return (p < 0) != (c < 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_drv = 0; m_up = 1; m_cnt = 0; m_pv = 0; m_pass = 0; m_fail = 0;
    end else if (start) begin
      m_st = 1; m_drv = 0; m_up = 1; m_cnt = 0; m_pv = 0; m_pass = 0; m_fail = 0;
    end else if (m_st == 1) begin
      bit cl;
      cl = m_up && rf && m_pv && sign_flip(m_prev, int'(fe)) && (m_cnt >= int'(blind));
      m_prev = int'(fe); m_pv = 1;
      if (cl) begin
        m_st = 2; m_cnt = 0;
      end else begin
        bit nu;
        if (ms_tick && m_cnt < 255) m_cnt++;
        nu = ramp_dir(m_drv, m_up, int'(amp), int'(stp));
        m_drv = ramp_val(m_drv, m_up, int'(amp), int'(stp));
        m_up = nu;
      end
    end else if (m_st == 2 && ms_tick) begin
      if (m_cnt + 1 >= int'(chk)) begin
        if (lpf) begin m_st = 3; m_pass = 1; end
        else begin m_st = 0; m_fail = 1; m_drv = 0; end
      end else m_cnt++;
    end
  end

  task automatic chk_eq(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk_eq("R3 search_drv", int'(drv), m_drv);
      chk_eq("R2 search_busy", int'(busy), int'(m_st == 1));
      chk_eq("R7 loop_closed", int'(closed), int'(m_st == 2 || m_st == 3));
      chk_eq("R8 lock_pass", int'(pass), int'(m_pass));
      chk_eq("R9 lock_fail", int'(fail), int'(m_fail));
    end
  end

  task automatic tick_clk(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      start = 0; ms_tick = 0;
    end
  endtask

  task automatic do_start(int a, int s, int b, int c);
    @(posedge clk); #2;
    amp = a[DW-2:0]; stp = s[DW-2:0]; blind = b[TW-1:0]; chk = c[TW-1:0];
    start = 1; ms_tick = 0;
    tick_clk(1);
  endtask

  task automatic pulse_ms(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; ms_tick = 1; start = 0;
      @(posedge clk); #2; ms_tick = 0;
    end
  endtask

  // watchdog
  initial begin
    while (cyc < 150000 && !done) @(posedge clk);
    if (!done) begin
      done = 1; errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick_clk(3);
    // R1: reset state
    chk_eq("R1 drv after reset", int'(drv), 0);
    chk_eq("R1 busy after reset", int'(busy), 0);
    chk_eq("R1 closed after reset", int'(closed), 0);
    chk_eq("R1 flags after reset", int'(pass) + int'(fail), 0);
    rst_n = 1;
    tick_clk(2);

    // R2/R3: start, ramp with no crossings (constant positive error)
    fe = 12'sd50; rf = 1;
    do_start(40, 7, 0, 1);
    chk_eq("R2 busy after start", int'(busy), 1);
    tick_clk(60);
    chk_eq("R5 no close without sign change", int'(closed), 0);

    // R4: crossings only while moving away from the disc
    do_start(30, 4, 0, 1);
    for (int i = 0; i < 80; i++) begin
      @(posedge clk); #2;
      fe = (!m_up) ? ((i % 2) ? 12'sd5 : -12'sd5) : 12'sd5;
    end
    chk_eq("R4 no close on downward sweep", int'(closed), 0);

    // R4: crossings without RF present
    rf = 0;
    do_start(30, 4, 0, 1);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #2; fe = (i % 2) ? 12'sd3 : -12'sd3;
    end
    chk_eq("R4 no close without RF", int'(closed), 0);

    // R6: blind period ignores crossings, then close
    rf = 1;
    do_start(500, 1, 3, 2);
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #2; fe = (i % 2) ? 12'sd9 : -12'sd9;
    end
    chk_eq("R6 blind keeps searching", int'(busy), 1);
    pulse_ms(2);
    chk_eq("R6 still blind after two ticks", int'(busy), 1);
    @(posedge clk); #2; ms_tick = 1; fe = -fe;
    @(posedge clk); #2; ms_tick = 0; fe = -fe;
    tick_clk(2);
    chk_eq("R6 closes after blind", int'(closed), 1);
    chk_eq("R7 busy low once closed", int'(busy), 0);

    // R8: pass at check
    lpf = 1;
    pulse_ms(1);
    chk_eq("R8 no pass before delay", int'(pass), 0);
    pulse_ms(1);
    chk_eq("R8 pass after delay", int'(pass), 1);
    tick_clk(10);
    chk_eq("R8 stays closed", int'(closed), 1);

    // R9: fail at check, then idle
    do_start(200, 3, 0, 0);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #2; fe = (i % 2) ? 12'sd4 : -12'sd4;
    end
    chk_eq("R4 closes on upward crossing", int'(closed), 1);
    lpf = 0;
    pulse_ms(1);
    chk_eq("R9 fail raised", int'(fail), 1);
    chk_eq("R9 loop opened", int'(closed), 0);
    chk_eq("R9 drive zero", int'(drv), 0);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #2; fe = (i % 2) ? 12'sd4 : -12'sd4; rf = 1;
    end
    chk_eq("R9 idle after fail", int'(busy) + int'(closed), 0);
    do_start(100, 5, 0, 0);
    chk_eq("R2 restart clears fail", int'(fail), 0);

    // random phase against the expected-state model
    for (int ep = 0; ep < 40; ep++) begin
      do_start(int'($urandom_range(0, 300)), int'($urandom_range(0, 40)),
               int'($urandom_range(0, 3)), int'($urandom_range(0, 4)));
      for (int i = 0; i < 300; i++) begin
        @(posedge clk); #2;
        fe = 12'(int'($urandom_range(0, 60)) - 30);
        rf = ($urandom_range(0, 9) < 7);
        lpf = ($urandom_range(0, 1) == 1);
        ms_tick = ($urandom_range(0, 5) == 0);
        start = ($urandom_range(0, 199) == 0);
      end
      start = 0; ms_tick = 0;
    end
    tick_clk(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
    $finish;
  end
endmodule